// File: doc/BRIEF.md
# Interval-Reported Edge Interrupt GPIO Port

This block is an eight-pin general-purpose digital port. Software controls it through one 32-bit control word, which holds three fields: an output data byte, a per-pin output-enable (direction) mask and a per-pin edge-interrupt enable mask. Each pad has a separate input, output and output-enable signal, so the pad ring builds the tristate buffer. A read of the word always returns the synchronised level on every pad, whatever its direction.

Edges on pins that have their interrupt enable bit set are not reported at once. Each level change, rising or falling, is held in a pending latch. The latch is copied into a visible edge flag only when the interval strobe `intv_tick` pulses, which marks the start of the next accumulation interval. The edge flag stays set until software clears it with the `flag_clr` strobe. An edge seen in the same cycle as the strobe is kept for the interval after it.

Top module: `gpio_interval_port`

## Requirements
- R1: After reset `pad_o`, `pad_oe` and `edge_flag` are all zero, and `reg_rdata[31:8]` reads as zero.
- R2: A write sets `pad_o[i]` to `reg_wdata[i]` only where the written direction bit `reg_wdata[16+i]` is 1. Every other `pad_o` bit keeps its previous value.
- R3: After a write, `pad_oe[i]` equals the written `reg_wdata[16+i]` (1 = output, 0 = input), and `reg_rdata[23:16]` reads back the same mask.
- R4: `reg_rdata[7:0]` returns the level of each pad after a two-flop synchroniser. A change on `pad_i` first appears on the read port two rising edges later. `reg_rdata[15:8]` always reads zero. `reg_rdata[31:24]` reads back the interrupt enable mask written at `reg_wdata[31:24]`.
- R5: A rising or falling transition on a synchronised pad whose enable bit `reg_wdata[24+i]` is set is captured as pending. Transitions on pads whose enable bit is clear are ignored.
- R6: `edge_flag` rises only in the cycle after an `intv_tick` pulse that finds an edge pending. An edge alone never raises the flag between strobes.
- R7: An `intv_tick` pulse clears the pending latch. A later strobe with no new edge leaves a cleared `edge_flag` at zero.
- R8: Once set, `edge_flag` stays set until a `flag_clr` pulse, which clears it on the next edge. If `flag_clr` and `intv_tick` arrive in the same cycle while an edge is pending, the flag stays set.
- R9: An edge detected in the same cycle as `intv_tick` is not reported by that strobe. It stays pending and is reported at the following strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data (pad levels, direction, enables) |
| pad_i | input | 8 | Pad input levels |
| pad_o | output | 8 | Pad output data |
| pad_oe | output | 8 | Pad output enables (1 = drive) |
| intv_tick | input | 1 | One-cycle accumulation interval boundary strobe |
| flag_clr | input | 1 | Write-one-to-clear strobe for the edge flag |
| edge_flag | output | 1 | Edge interrupt status flag |

## Verification
The bench writes direction masks that change between writes and checks that output bits of input-configured pins keep their old value. A design that wrote the whole data byte would show the new byte on those pins. It checks the read port at both one and two edges after a pad change, so a synchroniser with a missing or extra stage shows up. Edges are driven in both directions on enabled and masked pins, and the flag is checked before the strobe, so a design that reports edges at once or ignores falling edges is caught. An edge is placed exactly on the strobe cycle, and clear and strobe are issued together, which exposes a design that drops the coinciding edge or lets the clear win.

// File: rtl/gpio_ip_pkg.sv
package gpio_ip_pkg;
  localparam int REG_W    = 32;
  localparam int FIELD_W  = 8;
  localparam int DATA_LSB = 0;
  localparam int RSVD_LSB = 8;
  localparam int DIR_LSB  = 16;
  localparam int IEN_LSB  = 24;

  // Next value of one output data bit after a write.
  function automatic logic merge_bit(input logic old_v, input logic wr_v,
                                     input logic is_out);
    return is_out ? wr_v : old_v;
  endfunction

  // Per-pin enabled toggle detect.
  function automatic logic [FIELD_W-1:0] toggles(input logic [FIELD_W-1:0] cur,
                                                 input logic [FIELD_W-1:0] prev,
                                                 input logic [FIELD_W-1:0] en);
    return (cur ^ prev) & en;
  endfunction

  // Assemble the read word from its fields.
  function automatic logic [REG_W-1:0] pack_read(input logic [FIELD_W-1:0] lvl,
                                                 input logic [FIELD_W-1:0] dir,
                                                 input logic [FIELD_W-1:0] ien);
    logic [REG_W-1:0] w;
    w = '0;
    w[DATA_LSB +: FIELD_W] = lvl;
    w[DIR_LSB  +: FIELD_W] = dir;
    w[IEN_LSB  +: FIELD_W] = ien;
    return w;
  endfunction

  // Next state of the visible flag.
  function automatic logic flag_next(input logic cur, input logic clr,
                                     input logic tick, input logic pend);
    return (cur & ~clr) | (tick & pend);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_ip_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [NPINS-1:0] wr_data,
  input  logic [NPINS-1:0] wr_dir,
  input  logic [NPINS-1:0] wr_ien,
  output logic [NPINS-1:0] data_q,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] ien_q
);
  // Data bit i only takes the write when the new direction makes it an output.
  for (genvar i = 0; i < NPINS; i++) begin : g_data
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  data_q[i] <= 1'b0;
      else if (we) data_q[i] <= merge_bit(data_q[i], wr_data[i], wr_dir[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      ien_q <= '0;
    end else if (we) begin
      dir_q <= wr_dir;
      ien_q <= wr_ien;
    end
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_ip_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] lvl,
  input  logic [NPINS-1:0] ien,
  input  logic             tick,
  input  logic             clr,
  output logic             edge_hit,
  output logic             pend,
  output logic             flag
);
  logic [NPINS-1:0]   prev_q;
  logic [FIELD_W-1:0] lvl_x, prev_x, ien_x;

  always_comb begin
    lvl_x  = '0;
    prev_x = '0;
    ien_x  = '0;
    lvl_x[NPINS-1:0]  = lvl;
    prev_x[NPINS-1:0] = prev_q;
    ien_x[NPINS-1:0]  = ien;
  end

  assign edge_hit = |toggles(lvl_x, prev_x, ien_x);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend   <= 1'b0;
      flag   <= 1'b0;
    end else begin
      prev_q <= lvl;
      // A strobe hands the pending value over; an edge in that cycle starts the next interval.
      pend   <= tick ? edge_hit : (pend | edge_hit);
      flag   <= flag_next(flag, clr, tick, pend);
    end
  end
endmodule

// File: rtl/gpio_interval_port.sv
module gpio_interval_port
  import gpio_ip_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [NPINS-1:0] pad_i,
  output logic [NPINS-1:0] pad_o,
  output logic [NPINS-1:0] pad_oe,
  input  logic             intv_tick,
  input  logic             flag_clr,
  output logic             edge_flag
);
  logic [NPINS-1:0]   lvl_sync;
  logic [NPINS-1:0]   data_q, dir_q, ien_q;
  logic [FIELD_W-1:0] lvl_x, dir_x, ien_x;
  logic               edge_hit_w;
  logic               pend_w;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pad_i),
    .dout (lvl_sync)
  );

  gpio_regs #(.NPINS(NPINS)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (reg_we),
    .wr_data(reg_wdata[DATA_LSB +: NPINS]),
    .wr_dir (reg_wdata[DIR_LSB  +: NPINS]),
    .wr_ien (reg_wdata[IEN_LSB  +: NPINS]),
    .data_q (data_q),
    .dir_q  (dir_q),
    .ien_q  (ien_q)
  );

  gpio_edge_irq #(.NPINS(NPINS)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl     (lvl_sync),
    .ien     (ien_q),
    .tick    (intv_tick),
    .clr     (flag_clr),
    .edge_hit(edge_hit_w),
    .pend    (pend_w),
    .flag    (edge_flag)
  );

  always_comb begin
    lvl_x = '0;
    dir_x = '0;
    ien_x = '0;
    lvl_x[NPINS-1:0] = lvl_sync;
    dir_x[NPINS-1:0] = dir_q;
    ien_x[NPINS-1:0] = ien_q;
  end

  assign reg_rdata = pack_read(lvl_x, dir_x, ien_x);
  assign pad_o     = data_q;
  assign pad_oe    = dir_q;
endmodule

// File: rtl/gpio_interval_port_chk.sv
module gpio_interval_port_chk
  import gpio_ip_pkg::*;
#(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [REG_W-1:0] reg_wdata,
  input logic [NPINS-1:0] pad_o,
  input logic [NPINS-1:0] pad_oe,
  input logic             intv_tick,
  input logic             flag_clr,
  input logic             edge_flag,
  input logic             edge_hit,
  input logic             pend
);
  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> pad_oe == $past(reg_wdata[DIR_LSB +: NPINS])); // R3

  AST_OUT_BITS_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> ((pad_o ^ $past(reg_wdata[DATA_LSB +: NPINS])) & $past(reg_wdata[DIR_LSB +: NPINS])) == '0); // R2

  AST_IN_BITS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> ((pad_o ^ $past(pad_o)) & ~$past(reg_wdata[DIR_LSB +: NPINS])) == '0); // R2

  AST_FLAG_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(edge_flag) |-> $past(intv_tick)); // R6

  AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (intv_tick && !edge_hit) |=> !pend); // R7

  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !intv_tick) |=> !edge_flag); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_flag && !flag_clr) |=> edge_flag); // R8

  AST_TICK_EDGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (intv_tick && edge_hit) |=> pend); // R9
endmodule

bind gpio_interval_port gpio_interval_port_chk #(.NPINS(NPINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_we   (reg_we),
  .reg_wdata(reg_wdata),
  .pad_o    (pad_o),
  .pad_oe   (pad_oe),
  .intv_tick(intv_tick),
  .flag_clr (flag_clr),
  .edge_flag(edge_flag),
  .edge_hit (edge_hit_w),
  .pend     (pend_w)
);

// File: tb/gpio_interval_port_test.sv
module gpio_interval_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  pad_i = '0;
  logic [7:0]  pad_o, pad_oe;
  logic        intv_tick = 1'b0;
  logic        flag_clr = 1'b0;
  logic        edge_flag;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  gpio_interval_port uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe),
    .intv_tick(intv_tick), .flag_clr(flag_clr), .edge_flag(edge_flag)
  );

  // wdata, pads, expected pad_o, expected pad_oe, expected read word
  localparam int NV = 5;
  localparam logic [87:0] VEC [NV] = '{
    {32'h000F_00FF, 8'h30, 8'h0F, 8'h0F, 32'h000F_0030},
    {32'h00F0_0000, 8'hA5, 8'h0F, 8'hF0, 32'h00F0_00A5},
    {32'h00FF_A5C3, 8'h5A, 8'hC3, 8'hFF, 32'h00FF_005A},
    {32'h0081_007E, 8'hFF, 8'h42, 8'h81, 32'h0081_00FF},
    {32'h0000_00FF, 8'h00, 8'h42, 8'h00, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic tick_pulse();
    @(negedge clk); intv_tick = 1'b1;
    @(negedge clk); intv_tick = 1'b0;
  endtask

  task automatic clr_pulse();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pad_o", {24'h0, pad_o}, 32'h0);
    chk("R1 pad_oe", {24'h0, pad_oe}, 32'h0);
    chk("R1 rdata upper", {8'h0, reg_rdata[31:8]}, 32'h0);
    chk("R1 edge_flag", {31'h0, edge_flag}, 32'h0);
    rst_n = 1'b1;

    // Table walk: R2, R3, R4
    for (int v = 0; v < NV; v++) begin
      @(negedge clk); reg_we = 1'b1; reg_wdata = VEC[v][87:56]; pad_i = VEC[v][55:48];
      @(negedge clk); reg_we = 1'b0;
      @(negedge clk);
      chk("R2 pad_o", {24'h0, pad_o}, {24'h0, VEC[v][47:40]});
      chk("R3 pad_oe", {24'h0, pad_oe}, {24'h0, VEC[v][39:32]});
      chk("R4 rdata", reg_rdata, VEC[v][31:0]);
    end

    // R4 synchroniser latency
    @(negedge clk); pad_i = 8'h3C;
    @(negedge clk);
    chk("R4 one edge later", {24'h0, reg_rdata[7:0]}, 32'h0);
    @(negedge clk);
    chk("R4 two edges later", {24'h0, reg_rdata[7:0]}, 32'h3C);
    @(negedge clk); pad_i = 8'h00;
    settle(3);

    // Enable pin 0 only, read back enables
    wr(32'h0100_0000);
    chk("R4 ien readback", {24'h0, reg_rdata[31:24]}, 32'h01);

    // R5/R6 rising edge is deferred to the strobe
    @(negedge clk); pad_i[0] = 1'b1;
    settle(5);
    chk("R6 no flag before tick", {31'h0, edge_flag}, 32'h0);
    tick_pulse();
    chk("R6 flag after tick", {31'h0, edge_flag}, 32'h1);
    settle(4);
    chk("R8 flag sticky", {31'h0, edge_flag}, 32'h1);
    clr_pulse();
    chk("R8 flag cleared", {31'h0, edge_flag}, 32'h0);

    // R5 falling edge
    @(negedge clk); pad_i[0] = 1'b0;
    settle(4);
    tick_pulse();
    chk("R5 falling edge", {31'h0, edge_flag}, 32'h1);
    clr_pulse();

    // R5 masked pin ignored
    @(negedge clk); pad_i[1] = 1'b1;
    settle(4);
    tick_pulse();
    chk("R5 masked pin", {31'h0, edge_flag}, 32'h0);

    // R7 pending cleared by previous strobe
    tick_pulse();
    chk("R7 no new edge", {31'h0, edge_flag}, 32'h0);

    // R9 edge in the strobe cycle
    @(negedge clk); pad_i[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); intv_tick = 1'b1;
    @(negedge clk); intv_tick = 1'b0;
    chk("R9 not reported by same tick", {31'h0, edge_flag}, 32'h0);
    tick_pulse();
    chk("R9 reported at next tick", {31'h0, edge_flag}, 32'h1);

    // R8 clear and strobe together with an edge pending
    @(negedge clk); pad_i[0] = 1'b0;
    settle(4);
    @(negedge clk); flag_clr = 1'b1; intv_tick = 1'b1;
    @(negedge clk); flag_clr = 1'b0; intv_tick = 1'b0;
    chk("R8 tick beats clear", {31'h0, edge_flag}, 32'h1);
    clr_pulse();
    chk("R8 final clear", {31'h0, edge_flag}, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule